// File: doc/BRIEF.md
# Sticky Event Flags with Set/Clear Write Aliases

This block holds the interrupt flags and interrupt enables of a peripheral in one memory-mapped word. A parameterised number of hardware event lines (eight by default) each latch into a sticky status flag. The enable for flag k sits at bit k plus the flag count, so with eight flags it sits eight places higher. The interrupt line is the OR of every flag whose enable is set, delayed by one register.

Software reaches the word at three addresses. The base address writes the whole word. Base plus 4 ORs the written value in. Base plus 8 clears every bit that is written as 1. This lets a driver acknowledge one flag, or switch on one enable, in a single write and without a read-modify-write. A soft-clear input wipes all flags and enables.

Top module: `irq_alias_regs`

## Requirements
- R1: After hardware reset every status flag is 0, `irq_o` is 0, and the enable field holds `EN_RESET`. The default is 0x6F: enables on bits 0, 1, 2, 3, 5 and 6, and off for bit 4 (oversize) and bit 7 (bus free). The word therefore reads 0x0000_6F00.
- R2: A 1 on `evt_i[k]` sets status bit k of the word at the next clock edge. The bit stays set after the event line drops.
- R3: A write to `BASE_ADDR` + 0x00 loads status bits [N-1:0] and enable bits [2N-1:N] from `wdata_i`. Bits above 2N always read 0.
- R4: A write to `BASE_ADDR` + 0x04 ORs `wdata_i[2N-1:0]` into the word. Bits written as 0 keep their value.
- R5: A write to `BASE_ADDR` + 0x08 clears each word bit written as 1. Bits written as 0 keep their value.
- R6: When an event and a software write that would clear the same status bit fall in the same cycle, the bit ends up set. This applies to the clear alias and to a plain write of 0.
- R7: `irq_o` is 1 in the cycle after any status bit and its enable are both 1, and 0 in the cycle after no such pair exists. A flag whose enable is 0 never raises it.
- R8: `soft_clr_i` high at a clock edge clears every status and enable bit, taking priority over events and writes. `irq_o` falls one cycle later.
- R9: All three aliases read the same word. Any other address reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_clr_i | input | 1 | Synchronous clear of all flags and enables |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| evt_i | input | NUM_EVT | Hardware event lines, active high |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with `NUM_EVT` = 8, `DATA_W` = 32, `ADDR_W` = 8 and `BASE_ADDR` = 0x40. With the base placed off zero, unmapped addresses both below the base (0x3C) and above the clear alias (0x4C) can be reached. Those are the cases where a decoder that ignores the base or the offset width would go wrong. The default `EN_RESET` of 0x6F leaves bit 4 disabled after reset, so a latched but masked flag can be seen holding `irq_o` low.

// File: rtl/irq_alias_pkg.sv
`timescale 1ns/1ps
package irq_alias_pkg;
   // kind of write decoded from the address
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_PLAIN = 2'd1,
      WR_SET   = 2'd2,
      WR_CLR   = 2'd3
   } wr_kind_e;
endpackage

// File: rtl/irq_alias_decode.sv
`timescale 1ns/1ps
module irq_alias_decode
   import irq_alias_pkg::*;
#(
   parameter int unsigned            ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]      BASE_ADDR = '0,
   parameter int unsigned            SET_OFS   = 4,
   parameter int unsigned            CLR_OFS   = 8
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   output logic              hit_o,
   output wr_kind_e          kind_o
);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADDR + SET_OFS);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADDR + CLR_OFS);

   logic hit_plain, hit_set, hit_clr;

   assign hit_plain = (addr_i == BASE_ADDR);
   assign hit_set   = (addr_i == SET_A);
   assign hit_clr   = (addr_i == CLR_A);
   assign hit_o     = hit_plain | hit_set | hit_clr;

   always_comb begin
      kind_o = WR_NONE;
      if (we_i) begin
         if (hit_plain)    kind_o = WR_PLAIN;
         else if (hit_set) kind_o = WR_SET;
         else if (hit_clr) kind_o = WR_CLR;
      end
   end
endmodule

// File: rtl/irq_alias_cell.sv
`timescale 1ns/1ps
module irq_alias_cell
   import irq_alias_pkg::*;
#(
   parameter bit IS_STATUS = 1'b1,
   parameter bit RST_VAL   = 1'b0
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     soft_clr_i,
   input  wr_kind_e kind_i,
   input  logic     wbit_i,
   input  logic     evt_i,
   output logic     q_o
);
   logic sw_d, nxt;

   always_comb begin
      unique case (kind_i)
         WR_PLAIN: sw_d = wbit_i;
         WR_SET:   sw_d = q_o | wbit_i;
         WR_CLR:   sw_d = q_o & ~wbit_i;
         default:  sw_d = q_o;
      endcase
   end

   generate
      if (IS_STATUS) begin : g_status
         // an event in the same cycle beats any software clear
         assign nxt = sw_d | evt_i;
      end else begin : g_enable
         logic unused_evt;
         assign unused_evt = evt_i;
         assign nxt = sw_d;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o <= RST_VAL;
      else if (soft_clr_i) q_o <= 1'b0;
      else                 q_o <= nxt;
   end
endmodule

// File: rtl/irq_alias_out.sv
`timescale 1ns/1ps
module irq_alias_out #(
   parameter int unsigned NUM_EVT = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_EVT-1:0] stat_i,
   input  logic [NUM_EVT-1:0] en_i,
   output logic               irq_o
);
   logic pend;
   assign pend = |(stat_i & en_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= 1'b0;
      else         irq_o <= pend;
   end
endmodule

// File: rtl/irq_alias_regs.sv
`timescale 1ns/1ps
module irq_alias_regs
   import irq_alias_pkg::*;
#(
   parameter int unsigned             NUM_EVT   = 8,
   parameter int unsigned             DATA_W    = 32,
   parameter int unsigned             ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]       BASE_ADDR = '0,
   parameter logic [NUM_EVT-1:0]      EN_RESET  = NUM_EVT'(8'h6F)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               soft_clr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               we_i,
   output logic [DATA_W-1:0]  rdata_o,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               irq_o
);
   localparam int unsigned REG_W = 2 * NUM_EVT;

   generate
      if (NUM_EVT < 1 || REG_W > DATA_W) begin : g_bad_width
         $error("irq_alias_regs: 2*NUM_EVT must fit in DATA_W");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("irq_alias_regs: BASE_ADDR must be word aligned");
      end
   endgenerate

   wr_kind_e         kind;
   logic             hit;
   logic [REG_W-1:0] reg_q;

   irq_alias_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .SET_OFS   (4),
      .CLR_OFS   (8)
   ) i_decode (
      .addr_i (addr_i),
      .we_i   (we_i),
      .hit_o  (hit),
      .kind_o (kind)
   );

   for (genvar gi = 0; gi < REG_W; gi++) begin : g_bit
      localparam bit IS_ST = (gi < NUM_EVT);
      localparam bit RSTV  = IS_ST ? 1'b0 : EN_RESET[gi - (IS_ST ? 0 : NUM_EVT)];
      logic ev;
      if (IS_ST) begin : g_ev
         assign ev = evt_i[gi];
      end else begin : g_noev
         assign ev = 1'b0;
      end
      irq_alias_cell #(
         .IS_STATUS (IS_ST),
         .RST_VAL   (RSTV)
      ) i_cell (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .soft_clr_i (soft_clr_i),
         .kind_i     (kind),
         .wbit_i     (wdata_i[gi]),
         .evt_i      (ev),
         .q_o        (reg_q[gi])
      );
   end

   irq_alias_out #(
      .NUM_EVT (NUM_EVT)
   ) i_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stat_i (reg_q[NUM_EVT-1:0]),
      .en_i   (reg_q[REG_W-1:NUM_EVT]),
      .irq_o  (irq_o)
   );

   assign rdata_o = hit ? DATA_W'(reg_q) : '0;
endmodule

// File: rtl/irq_alias_chk.sv
`timescale 1ns/1ps
module irq_alias_chk #(
   parameter int unsigned        NUM_EVT   = 8,
   parameter int unsigned        DATA_W    = 32,
   parameter int unsigned        ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]  BASE_ADDR = '0
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   soft_clr_i,
   input logic [ADDR_W-1:0]      addr_i,
   input logic [DATA_W-1:0]      wdata_i,
   input logic                   we_i,
   input logic [NUM_EVT-1:0]     evt_i,
   input logic                   irq_o,
   input logic [2*NUM_EVT-1:0]   reg_q
);
   localparam int unsigned REG_W = 2 * NUM_EVT;
   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE_ADDR + 4);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE_ADDR + 8);

   logic pend, mapped;
   assign pend   = |(reg_q[NUM_EVT-1:0] & reg_q[REG_W-1:NUM_EVT]);
   assign mapped = (addr_i == BASE_ADDR) || (addr_i == A_SET) || (addr_i == A_CLR);

   assert_evt_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0 && !soft_clr_i) |=>
         ((reg_q[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));

   assert_set_or_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_SET && !soft_clr_i) |=>
         ((reg_q & $past(wdata_i[REG_W-1:0])) == $past(wdata_i[REG_W-1:0])));

   assert_clr_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_CLR && evt_i == '0) |=>
         ((reg_q & $past(wdata_i[REG_W-1:0])) == '0));

   assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend |=> irq_o);

   assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend |=> !irq_o);

   assert_soft_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_clr_i |=> (reg_q == '0));

   assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !mapped && evt_i == '0 && !soft_clr_i) |=> $stable(reg_q));
endmodule

bind irq_alias_regs irq_alias_chk #(
   .NUM_EVT   (NUM_EVT),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR)
) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .soft_clr_i (soft_clr_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .we_i       (we_i),
   .evt_i      (evt_i),
   .irq_o      (irq_o),
   .reg_q      (reg_q)
);

// File: tb/test_irq_alias_regs.sv
`timescale 1ns/1ps
module test_irq_alias_regs;
   localparam int unsigned NE = 8;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 8;
   localparam logic [AW-1:0] BASE = 8'h40;
   localparam logic [AW-1:0] A_SET = 8'h44;
   localparam logic [AW-1:0] A_CLR = 8'h48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_clr = 1'b0;
   logic [AW-1:0] addr = BASE;
   logic [DW-1:0] wdata = '0;
   logic          we = 1'b0;
   logic [DW-1:0] rdata;
   logic [NE-1:0] evt = '0;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_alias_regs #(
      .NUM_EVT   (NE),
      .DATA_W    (DW),
      .ADDR_W    (AW),
      .BASE_ADDR (BASE),
      .EN_RESET  (8'h6F)
   ) i_irq_alias_regs (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .soft_clr_i (soft_clr),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .we_i       (we),
      .rdata_o    (rdata),
      .evt_i      (evt),
      .irq_o      (irq)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   // one write cycle with optional events; returns at the next falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NE-1:0] e);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1; evt = e;
      @(negedge clk);
      we = 1'b0; evt = '0; addr = BASE;
   endtask

   task automatic pulse_evt(input logic [NE-1:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic do_hard_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      rd(BASE, v);
      chk("R1 reset word", v, 32'h0000_6F00);
      chk("R1 reset irq", DW'(irq), 32'h0);
   endtask

   task automatic t_event_irq();
      logic [DW-1:0] v;
      pulse_evt(8'h10);                 // bit 4 masked by default
      rd(BASE, v);
      chk("R2 sticky bit4", v, 32'h0000_6F10);
      @(negedge clk);
      chk("R7 masked flag keeps irq low", DW'(irq), 32'h0);
      pulse_evt(8'h40);                 // bit 6 enabled
      rd(BASE, v);
      chk("R2 sticky bit6", v, 32'h0000_6F50);
      chk("R7 irq not yet (one cycle lag)", DW'(irq), 32'h0);
      @(negedge clk);
      chk("R7 irq high", DW'(irq), 32'h1);
   endtask

   task automatic t_clear_alias();
      logic [DW-1:0] v;
      wr(A_CLR, 32'h0000_0040, '0);
      rd(BASE, v);
      chk("R5 clear only bit6", v, 32'h0000_6F10);
      @(negedge clk);
      chk("R7 irq falls after clear", DW'(irq), 32'h0);
   endtask

   task automatic t_set_alias();
      logic [DW-1:0] v;
      wr(A_SET, 32'h0000_1000, '0);
      rd(BASE, v);
      chk("R4 set enable bit12", v, 32'h0000_7F10);
      @(negedge clk);
      chk("R7 irq from newly enabled flag", DW'(irq), 32'h1);
      wr(A_SET, 32'h0000_0004, '0);
      rd(BASE, v);
      chk("R4 set status bit2 keeps others", v, 32'h0000_7F14);
   endtask

   task automatic t_aliases_unmapped();
      logic [DW-1:0] v;
      rd(A_SET, v);
      chk("R9 read via set alias", v, 32'h0000_7F14);
      rd(A_CLR, v);
      chk("R9 read via clear alias", v, 32'h0000_7F14);
      rd(8'h4C, v);
      chk("R9 unmapped read above", v, 32'h0);
      wr(8'h4C, 32'hFFFF_FFFF, '0);
      wr(8'h3C, 32'h0000_0000, '0);
      wr(8'h00, 32'h0000_0000, '0);
      rd(BASE, v);
      chk("R9 unmapped writes ignored", v, 32'h0000_7F14);
   endtask

   task automatic t_plain();
      logic [DW-1:0] v;
      wr(BASE, 32'hFFFF_00A5, '0);
      rd(BASE, v);
      chk("R3 plain write, upper bits zero", v, 32'h0000_00A5);
      @(negedge clk);
      chk("R7 no enables, irq low", DW'(irq), 32'h0);
   endtask

   task automatic t_collision();
      logic [DW-1:0] v;
      wr(A_CLR, 32'h0000_00FF, 8'h02);
      rd(BASE, v);
      chk("R6 event beats clear alias", v, 32'h0000_0002);
      wr(BASE, 32'h0000_0000, 8'h08);
      rd(BASE, v);
      chk("R6 event beats plain zero write", v, 32'h0000_0008);
   endtask

   task automatic t_soft();
      logic [DW-1:0] v;
      wr(A_SET, 32'h0000_FF00, '0);
      @(negedge clk);
      chk("R8 irq up before soft clear", DW'(irq), 32'h1);
      soft_clr = 1'b1; evt = 8'h01;
      @(negedge clk);
      soft_clr = 1'b0; evt = '0;
      rd(BASE, v);
      chk("R8 soft clear wipes word", v, 32'h0);
      @(negedge clk);
      chk("R8 irq low after soft clear", DW'(irq), 32'h0);
   endtask

   task automatic t_rereset();
      logic [DW-1:0] v;
      wr(BASE, 32'h0000_00FF, '0);
      do_hard_reset();
      rd(BASE, v);
      chk("R1 hard reset restores default", v, 32'h0000_6F00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_event_irq();
      t_clear_alias();
      t_set_alias();
      t_aliases_unmapped();
      t_plain();
      t_collision();
      t_soft();
      t_rereset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule